// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block decides which commands a serial flash slave may act on. It samples chip select, the serial clock and the serial data input on the system clock. It captures the first byte of each chip-select frame as the opcode and counts every serial-clock rising edge in the frame. When chip select rises, it judges the frame as a whole. A frame is used only if it carried at least one full byte and its clock count is an exact multiple of eight.

The guard holds a write-enable latch, a busy flag for the modifying operation in progress, and the deep power-down state. A modifying command starts only when all of the following hold:
- the frame is well formed;
- the latch was already set by an earlier enable command;
- no operation is running;
- the device is awake;
- the power-up wait has elapsed.

An accepted command produces a single-cycle start pulse and the opcode for the array controller. When the array controller reports completion on its done input, the latch clears and the busy flag drops.

Opcodes used by the block:
- Set latch: 06h.
- Clear latch: 04h.
- Enter deep power-down: B9h.
- Release from deep power-down: ABh.
- Modifying commands (eight): 02h, 0Ah, D8h, 20h, DBh, C7h, E5h and 01h.

Top module: `flash_wp_guard`

## Requirements
- R1: After power reset, `welOut`, `busyOut`, `powerDown` and `startValid` are all 0. A well-formed 06h frame sets `welOut` to 1 on the cycle after chip select rises.
- R2: A modifying opcode sent while `welOut` is 0 produces no start pulse and leaves `busyOut` at 0.
- R3: With the latch set, the device awake, no operation running and the power-up wait elapsed, a well-formed frame whose first byte is one of the eight modifying opcodes raises `startValid`, with `startOp` equal to that opcode and `busyOut` set. This happens one cycle after the chip-select rise is sampled, never earlier.
- R4: A frame is discarded, whatever its opcode (including 06h and 04h), if its number of serial-clock rising edges is below 8 or not a multiple of 8.
- R5: A well-formed 04h frame clears `welOut`.
- R6: `welOut` stays 1 after a command is accepted. It clears, together with `busyOut`, on the cycle after `opDone` is sampled high while busy.
- R7: While `busyOut` is 1, modifying, 06h and 04h frames are ignored: there is no start pulse and `welOut` is unchanged.
- R8: While `resetPinN` is low, `welOut` and `powerDown` are forced to 0 and the frame in progress is abandoned. A frame that spans a low pulse on `resetPinN` never starts a command.
- R9: After power reset, modifying commands are ignored until `pwrWait`+1 clock cycles have passed. Commands 06h and 04h still act during this wait.
- R10: A well-formed B9h frame sets `powerDown`. While it is set, every frame except ABh is ignored, and a well-formed ABh frame clears it.
- R11: `startValid` is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| resetPinN | input | 1 | Device reset input, active low, sampled |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| mosi | input | 1 | Serial data in, most significant bit first |
| opDone | input | 1 | Completion pulse from the array controller |
| pwrWait | input | 16 | Power-up wait length in clock cycles |
| startValid | output | 1 | One-cycle pulse for an accepted modifying command |
| startOp | output | 8 | Opcode of the last accepted command |
| welOut | output | 1 | Write-enable latch state |
| busyOut | output | 1 | A modifying operation is in progress |
| powerDown | output | 1 | Deep power-down state |

## Verification
The hardest case to reach is a frame that is well formed on its own but lands on a blocking condition. Examples are a frame cut by a reset-pin pulse halfway through its opcode, or a latch command arriving while an accepted operation has not yet reported done. The bench creates these cases deliberately:
- A frame task can pulse `resetPinN` before a chosen bit, and the frame then completes normally.
- The done pulse is held back while enable, disable and further modifying frames are sent.

The power-up case is reached by programming a long wait and issuing a fully enabled program command inside that window, then issuing it again once the window has passed.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  localparam logic [7:0] OP_SETWEL  = 8'h06;
  localparam logic [7:0] OP_CLRWEL  = 8'h04;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_PGWRITE = 8'h0A;
  localparam logic [7:0] OP_SECTER  = 8'hD8;
  localparam logic [7:0] OP_SUBER   = 8'h20;
  localparam logic [7:0] OP_PGERASE = 8'hDB;
  localparam logic [7:0] OP_BULKER  = 8'hC7;
  localparam logic [7:0] OP_LOCKWR  = 8'hE5;
  localparam logic [7:0] OP_STATWR  = 8'h01;
  localparam logic [7:0] OP_SLEEP   = 8'hB9;
  localparam logic [7:0] OP_WAKE    = 8'hAB;

  // Strobes sent from the control to the frame datapath.
  typedef struct packed {
    logic clear;
    logic shift;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    CLS_OTHER,
    CLS_SETWEL,
    CLS_CLRWEL,
    CLS_MODIFY,
    CLS_SLEEP,
    CLS_WAKE
  } cmdClass_t;

  function automatic cmdClass_t classify(input logic [7:0] op);
    case (op)
      OP_SETWEL: classify = CLS_SETWEL;
      OP_CLRWEL: classify = CLS_CLRWEL;
      OP_SLEEP:  classify = CLS_SLEEP;
      OP_WAKE:   classify = CLS_WAKE;
      OP_PROG, OP_PGWRITE, OP_SECTER, OP_SUBER,
      OP_PGERASE, OP_BULKER, OP_LOCKWR, OP_STATWR:
                 classify = CLS_MODIFY;
      default:   classify = CLS_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/wpg_frame_dp.sv
// Frame datapath: captures the first byte of a frame and tracks the bit count modulo the byte width.
module wpg_frame_dp
  import wpg_pkg::*;
#(
  parameter int BYTE_W = 8  // must be a power of two
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              mosi,
  output logic [BYTE_W-1:0] frameByte,
  output logic              frameHasByte,
  output logic              frameAligned
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              gotByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      gotByte  <= 1'b0;
    end else if (strobe.clear) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      gotByte  <= 1'b0;
    end else if (strobe.shift) begin
      bitCnt <= bitCnt + 1'b1;
      if (!gotByte) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], mosi};
        if (bitCnt == LAST_BIT) gotByte <= 1'b1;
      end
    end
  end

  assign frameByte    = shiftReg;
  assign frameHasByte = gotByte;
  assign frameAligned = (bitCnt == '0);

endmodule

// File: rtl/wpg_pu_timer.sv
// Power-up inhibit: readiness rises once the programmed wait has elapsed.
module wpg_pu_timer #(
  parameter int PU_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PU_W-1:0] waitCycles,
  output logic            puReady
);
  logic [PU_W-1:0] elapsed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
      puReady <= 1'b0;
    end else if (!puReady) begin
      if (elapsed >= waitCycles) puReady <= 1'b1;
      else                       elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/wpg_ctrl.sv
// Control: edge detection, acceptance rules, latch, busy and deep power-down state.
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       resetPinN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       opDone,
  input  logic       puReady,
  input  logic [7:0] frameByte,
  input  logic       frameHasByte,
  input  logic       frameAligned,
  output dpStrobe_t  strobe,
  output logic       startValid,
  output logic [7:0] startOp,
  output logic       welOut,
  output logic       busyOut,
  output logic       powerDown
);
  logic      csPrev, sclkPrev;
  logic      csFall, csRise, sclkRise;
  logic      frameOk, acceptMod;
  cmdClass_t cls;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
    end
  end

  always_comb begin
    csFall       = csPrev && !csN;
    csRise       = !csPrev && csN;
    sclkRise     = !sclkPrev && sclk && !csN;
    strobe.clear = csFall || !resetPinN;
    strobe.shift = sclkRise && resetPinN;
    cls          = classify(frameByte);
    frameOk      = csRise && resetPinN && frameHasByte && frameAligned;
    acceptMod    = frameOk && !powerDown && !busyOut && welOut && puReady
                   && (cls == CLS_MODIFY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startValid <= 1'b0;
      startOp    <= '0;
      welOut     <= 1'b0;
      busyOut    <= 1'b0;
      powerDown  <= 1'b0;
    end else begin
      startValid <= acceptMod;
      if (acceptMod) startOp <= frameByte;

      if (acceptMod)   busyOut <= 1'b1;
      else if (opDone) busyOut <= 1'b0;

      if (!resetPinN)              welOut <= 1'b0;
      else if (busyOut && opDone)  welOut <= 1'b0;
      else if (frameOk && !powerDown && !busyOut) begin
        if (cls == CLS_SETWEL)      welOut <= 1'b1;
        else if (cls == CLS_CLRWEL) welOut <= 1'b0;
      end

      if (!resetPinN) powerDown <= 1'b0;
      else if (frameOk && powerDown && cls == CLS_WAKE) powerDown <= 1'b0;
      else if (frameOk && !powerDown && !busyOut && cls == CLS_SLEEP) powerDown <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import wpg_pkg::*;
#(
  parameter int PU_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resetPinN,
  input  logic            csN,
  input  logic            sclk,
  input  logic            mosi,
  input  logic            opDone,
  input  logic [PU_W-1:0] pwrWait,
  output logic            startValid,
  output logic [7:0]      startOp,
  output logic            welOut,
  output logic            busyOut,
  output logic            powerDown
);
  localparam int OP_W = 8;

  dpStrobe_t       strobe;
  logic [OP_W-1:0] frameByte;
  logic            frameHasByte, frameAligned, puReady;

  wpg_frame_dp #(.BYTE_W(OP_W)) frame_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mosi(mosi),
    .frameByte(frameByte), .frameHasByte(frameHasByte), .frameAligned(frameAligned)
  );

  wpg_pu_timer #(.PU_W(PU_W)) timer_i (
    .clk(clk), .rstN(rstN), .waitCycles(pwrWait), .puReady(puReady)
  );

  wpg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .resetPinN(resetPinN), .csN(csN), .sclk(sclk),
    .opDone(opDone), .puReady(puReady), .frameByte(frameByte),
    .frameHasByte(frameHasByte), .frameAligned(frameAligned), .strobe(strobe),
    .startValid(startValid), .startOp(startOp), .welOut(welOut),
    .busyOut(busyOut), .powerDown(powerDown)
  );

endmodule

// File: rtl/wpg_chk.sv
module wpg_chk (
  input logic clk,
  input logic rstN,
  input logic resetPinN,
  input logic csN,
  input logic opDone,
  input logic startValid,
  input logic welOut,
  input logic busyOut,
  input logic powerDown
);
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> $past(welOut)); // R2
  AST_START_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> ($past(csN, 1) && !$past(csN, 2))); // R3
  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && opDone) |=> (!welOut && !busyOut)); // R6
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> !$past(busyOut)); // R7
  AST_RESET_PIN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !resetPinN |=> (!welOut && !powerDown)); // R8
  AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> !$past(powerDown)); // R10
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> !startValid); // R11
endmodule

bind flash_wp_guard wpg_chk chk_i (
  .clk(clk), .rstN(rstN), .resetPinN(resetPinN), .csN(csN), .opDone(opDone),
  .startValid(startValid), .welOut(welOut), .busyOut(busyOut), .powerDown(powerDown)
);

// File: tb/flash_wp_guard_tb_top.sv
module flash_wp_guard_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetPinN = 1'b1;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic        opDone = 1'b0;
  logic [15:0] pwrWait = 16'd100;
  logic        startValid, welOut, busyOut, powerDown;
  logic [7:0]  startOp;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_wp_guard dut_i (
    .clk(clk), .rstN(rstN), .resetPinN(resetPinN), .csN(csN), .sclk(sclk),
    .mosi(mosi), .opDone(opDone), .pwrWait(pwrWait), .startValid(startValid),
    .startOp(startOp), .welOut(welOut), .busyOut(busyOut), .powerDown(powerDown)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sends one frame of nBits clocks: opcode first, then zeros. rstAt >= 0 pulses resetPinN before that bit.
  task automatic frame(input logic [7:0] op, input int nBits, input int rstAt,
                       output logic sawStart, output logic [7:0] sawOp, output logic longPulse);
    @(negedge clk); csN = 1'b0; sclk = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      if (i == rstAt) begin
        resetPinN = 1'b0;
        repeat (3) @(negedge clk);
        resetPinN = 1'b1;
      end
      @(negedge clk); mosi = (i < 8) ? op[7-i] : 1'b0; sclk = 1'b0;
      @(negedge clk); sclk = 1'b1;
    end
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); csN = 1'b1;
    @(negedge clk); sawStart = startValid; sawOp = startOp;
    @(negedge clk); longPulse = startValid;
  endtask

  task automatic done();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  logic s, p; logic [7:0] o;

  task automatic testReset();
    chk("R1 reset wel", welOut, 0);
    chk("R1 reset busy", busyOut, 0);
    chk("R1 reset powerDown", powerDown, 0);
    chk("R1 reset start", startValid, 0);
  endtask

  task automatic testPowerUp();
    frame(8'h06, 8, -1, s, o, p);
    chk("R9 enable acts during wait", welOut, 1);
    frame(8'h02, 8, -1, s, o, p);
    chk("R9 no start during wait", s, 0);
    chk("R9 busy idle during wait", busyOut, 0);
    repeat (80) @(negedge clk);
    frame(8'h02, 8, -1, s, o, p);
    chk("R9 start after wait", s, 1);
    chk("R3 opcode", o, 8'h02);
    chk("R6 wel held while busy", welOut, 1);
    done();
    chk("R6 wel cleared by done", welOut, 0);
    chk("R6 busy cleared by done", busyOut, 0);
  endtask

  task automatic testNoWel();
    frame(8'hD8, 8, -1, s, o, p);
    chk("R2 no start without wel", s, 0);
    chk("R2 busy stays low", busyOut, 0);
  endtask

  task automatic testFrameLength();
    frame(8'h06, 9, -1, s, o, p);
    chk("R4 9-clock enable discarded", welOut, 0);
    frame(8'h06, 7, -1, s, o, p);
    chk("R4 7-clock enable discarded", welOut, 0);
    frame(8'h06, 16, -1, s, o, p);
    chk("R4 16-clock enable accepted", welOut, 1);
    frame(8'h02, 12, -1, s, o, p);
    chk("R4 12-clock program discarded", s, 0);
    chk("R4 wel kept after discard", welOut, 1);
    frame(8'hD8, 32, -1, s, o, p);
    chk("R3 32-clock erase starts", s, 1);
    chk("R3 erase opcode", o, 8'hD8);
    frame(8'h04, 8, -1, s, o, p);
    chk("R7 disable ignored while busy", welOut, 1);
    frame(8'h20, 8, -1, s, o, p);
    chk("R7 no start while busy", s, 0);
    done();
    frame(8'h06, 8, -1, s, o, p);
    done();
    chk("R6 idle done leaves wel", welOut, 1);
    frame(8'h04, 8, -1, s, o, p);
    chk("R5 disable clears wel", welOut, 0);
  endtask

  task automatic testAllModify();
    logic [7:0] ops [8] = '{8'h02, 8'h0A, 8'hD8, 8'h20, 8'hDB, 8'hC7, 8'hE5, 8'h01};
    for (int k = 0; k < 8; k++) begin
      frame(8'h06, 8, -1, s, o, p);
      frame(ops[k], 8, -1, s, o, p);
      chk("R3 modify start", s, 1);
      chk("R3 modify opcode", o, ops[k]);
      chk("R11 single-cycle pulse", p, 0);
      done();
      chk("R6 done clears wel", welOut, 0);
    end
  endtask

  task automatic testSleep();
    frame(8'hB9, 8, -1, s, o, p);
    chk("R10 enter power-down", powerDown, 1);
    frame(8'h06, 8, -1, s, o, p);
    chk("R10 enable ignored asleep", welOut, 0);
    frame(8'hAB, 8, -1, s, o, p);
    chk("R10 wake clears power-down", powerDown, 0);
    frame(8'h06, 8, -1, s, o, p);
    chk("R10 enable works after wake", welOut, 1);
  endtask

  task automatic testResetPin();
    frame(8'h02, 8, 4, s, o, p);
    chk("R8 split frame not started", s, 0);
    chk("R8 reset pin clears wel", welOut, 0);
    frame(8'hB9, 8, -1, s, o, p);
    @(negedge clk); resetPinN = 1'b0;
    @(negedge clk);
    chk("R8 reset pin clears power-down", powerDown, 0);
    resetPinN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPowerUp();
    testNoWel();
    testFrameLength();
    testAllModify();
    testSleep();
    testResetPin();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule